// File: doc/BRIEF.md
# Cache Tag Store with Match Comparator

This block is the tag memory of a direct-mapped cache. Each entry holds a tag field and two status flags, valid and dirty. An address picks one entry. The stored tag of that entry is compared with a probe tag on the input, and a single active-high `hit` output reports whether they agree. A mode input, `need_valid`, decides whether the stored valid flag must also be set before a hit is reported. The dirty flag is stored and read back and never affects the hit.

Writes of the tag and the flags are taken on the rising clock edge. Reads and the hit result are combinational from the stored contents, the address and the probe tag, so they need no clock edge. An active-low clear input wipes the valid and dirty flags of every entry at once and leaves the tags as they were. Two chip selects of opposite polarity must both be active, and the sleep input must be low, before the block reads, writes or reports a hit. A decoder can therefore stack several blocks in depth, with their hit outputs ORed together. The default depth is 256 entries (`ADDR_W` = 8). Setting `ADDR_W` to 13 gives 8192 entries.

Top module: `tag_store`

## Requirements
- R1: When the block is enabled (`sel_n` = 0, `sel` = 1, `sleep` = 0) and `wr_en` = 1, the rising clock edge stores `tag_in`, `valid_in` and `dirty_in` at `addr`. A later read of that address returns them.
- R2: With `need_valid` = 0, `hit` is 1 exactly when the enabled block's stored tag at `addr` equals `tag_in`, whatever the stored valid flag is.
- R3: With `need_valid` = 1, `hit` also requires the stored valid flag at `addr` to be 1.
- R4: The stored dirty flag has no effect on `hit`.
- R5: `hit`, `tag_out`, `valid_out` and `dirty_out` follow changes of `addr` and `tag_in` within the same cycle, with no clock edge in between.
- R6: While `clear_n` = 0, the valid and dirty flags of every entry read as 0. The stored tags are kept and still compare.
- R7: If `sel_n` = 1, `sel` = 0 or `sleep` = 1, then no write takes place, `hit` is 0 and `rd_ok` is 0.
- R8: `rd_ok` is 1 exactly when the block is enabled, `rd_en` = 1 and `wr_en` = 0. When `rd_ok` is 0, `tag_out`, `valid_out` and `dirty_out` are 0.
- R9: A write while `clear_n` = 0 discards its valid and dirty values, but the tag it carries is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| clear_n | input | 1 | Active-low clear of all status flags |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| sleep | input | 1 | Low-power mode; blocks all accesses |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read output enable |
| need_valid | input | 1 | 1: the hit requires the valid flag |
| addr | input | ADDR_W | Entry select |
| tag_in | input | TAG_W | Probe tag and write data |
| valid_in | input | 1 | Valid flag write data |
| dirty_in | input | 1 | Dirty flag write data |
| hit | output | 1 | Tag match result |
| rd_ok | output | 1 | Read data is driven |
| tag_out | output | TAG_W | Stored tag at addr |
| valid_out | output | 1 | Stored valid flag at addr |
| dirty_out | output | 1 | Stored dirty flag at addr |

## Verification
The assertions check on every cycle that:
- a write lands in the status flags when it is enabled and outside a clear;
- the flags hold still when no write is enabled;
- every flag is zero on the first edge after a clear ends;
- a hit reported with `need_valid` set always comes with a set valid flag;
- `hit` stays low when the block is deselected or asleep.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- the tags survive a clear;
- the dirty flag has no effect on `hit`;
- the outputs respond within the cycle to an address or tag change;
- a write during a clear is split, keeping the tag and dropping the flags.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;

    // One status entry as seen at the read port
    typedef struct packed {
        logic valid;
        logic dirty;
    } status_t;

endpackage

// File: rtl/tag_status_array.sv
module tag_status_array #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     clear_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  tag_store_pkg::status_t   st_in,
    output tag_store_pkg::status_t   st_out
);
    typedef struct packed {
        logic [DEPTH-1:0] v;
        logic [DEPTH-1:0] d;
    } flags_t;

    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we) begin
            flags_d.v[addr] = st_in.valid;
            flags_d.d[addr] = st_in.dirty;
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) flags_q <= '0;
        else          flags_q <= flags_d;
    end

    assign st_out.valid = flags_q.v[addr];
    assign st_out.dirty = flags_q.d[addr];

    // R1: an enabled write outside a clear lands in the flags
    a_r1_status_write: assert property (@(posedge clk) disable iff (!clear_n)
        we |=> (flags_q.v[$past(addr)] == $past(st_in.valid))
            && (flags_q.d[$past(addr)] == $past(st_in.dirty)));

    // R7: without a write the flags do not move
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!clear_n)
        !we |=> ($stable(flags_q.v) && $stable(flags_q.d)));

    // R6: the first edge after a clear sees every flag at zero
    a_r6_cleared: assert property (@(posedge clk) disable iff (!clear_n)
        $rose(clear_n) |-> (flags_q.v == '0 && flags_q.d == '0));
endmodule

// File: rtl/tag_data_array.sv
module tag_data_array #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 14,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_wr,
    output logic [TAG_W-1:0]  tag_rd
);
    // Tag storage carries no reset: a clear only touches the flags
    logic [TAG_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= tag_wr;
    end

    assign tag_rd = mem_q[addr];
endmodule

// File: rtl/tag_compare.sv
module tag_compare #(
    parameter int TAG_W = 14
) (
    input  logic             enable,
    input  logic             need_valid,
    input  logic             stored_valid,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    logic [TAG_W-1:0] bit_eq;

    for (genvar i = 0; i < TAG_W; i++) begin : g_bit
        assign bit_eq[i] = ~(stored_tag[i] ^ probe_tag[i]);
    end

    assign hit = enable && (&bit_eq) && (!need_valid || stored_valid);
endmodule

// File: rtl/tag_store.sv
module tag_store #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 14
) (
    input  logic              clk,
    input  logic              clear_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              sleep,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              need_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              valid_in,
    input  logic              dirty_in,
    output logic              hit,
    output logic              rd_ok,
    output logic [TAG_W-1:0]  tag_out,
    output logic              valid_out,
    output logic              dirty_out
);
    import tag_store_pkg::*;

    logic             active;
    logic             wr_go;
    status_t          st_wr, st_rd;
    logic [TAG_W-1:0] tag_rd;

    assign active = !sel_n && sel && !sleep;
    assign wr_go  = active && wr_en;
    assign st_wr  = '{valid: valid_in, dirty: dirty_in};

    tag_data_array #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .we     (wr_go),
        .addr   (addr),
        .tag_wr (tag_in),
        .tag_rd (tag_rd)
    );

    tag_status_array #(.ADDR_W(ADDR_W)) u_flags (
        .clk     (clk),
        .clear_n (clear_n),
        .we      (wr_go),
        .addr    (addr),
        .st_in   (st_wr),
        .st_out  (st_rd)
    );

    tag_compare #(.TAG_W(TAG_W)) u_cmp (
        .enable       (active),
        .need_valid   (need_valid),
        .stored_valid (st_rd.valid),
        .stored_tag   (tag_rd),
        .probe_tag    (tag_in),
        .hit          (hit)
    );

    assign rd_ok     = active && rd_en && !wr_en;
    assign tag_out   = rd_ok ? tag_rd      : '0;
    assign valid_out = rd_ok && st_rd.valid;
    assign dirty_out = rd_ok && st_rd.dirty;

    // R3: a qualified hit always comes with a set valid flag
    a_r3_qualified_hit: assert property (@(posedge clk) disable iff (!clear_n)
        (hit && need_valid) |-> st_rd.valid);

    // R7: a deselected or sleeping block never reports a hit
    a_r7_idle_no_hit: assert property (@(posedge clk) disable iff (!clear_n)
        (sel_n || !sel || sleep) |-> !hit);
endmodule

// File: tb/test_tag_store.sv
module test_tag_store;
    localparam int AW = 8;
    localparam int TW = 14;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic clear_n = 1'b0;
    logic sel_n = 1'b1, sel = 1'b0, sleep = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, need_valid = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [TW-1:0] tag_in = '0;
    logic valid_in = 1'b0, dirty_in = 1'b0;
    logic hit, rd_ok, valid_out, dirty_out;
    logic [TW-1:0] tag_out;

    int n_chk = 0, n_fail = 0;
    logic [TW-1:0] m_tag [DEPTH];
    logic m_v [DEPTH];
    logic m_d [DEPTH];

    always #2.5 clk = ~clk;

    tag_store #(.ADDR_W(AW), .TAG_W(TW)) i_tag_store (
        .clk(clk), .clear_n(clear_n), .sel_n(sel_n), .sel(sel), .sleep(sleep),
        .wr_en(wr_en), .rd_en(rd_en), .need_valid(need_valid), .addr(addr),
        .tag_in(tag_in), .valid_in(valid_in), .dirty_in(dirty_in), .hit(hit),
        .rd_ok(rd_ok), .tag_out(tag_out), .valid_out(valid_out), .dirty_out(dirty_out)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic exp_active();
        return !sel_n && sel && !sleep;
    endfunction

    function automatic logic exp_hit();
        return exp_active() && (m_tag[addr] == tag_in) && (!need_valid || m_v[addr]);
    endfunction

    function automatic logic exp_rd();
        return exp_active() && rd_en && !wr_en;
    endfunction

    // Full comparison of every output against the model
    task automatic check_all(string req);
        chk({req, " hit"}, 32'(hit), 32'(exp_hit()));
        chk({req, " rd_ok"}, 32'(rd_ok), 32'(exp_rd()));
        chk({req, " tag_out"}, 32'(tag_out), exp_rd() ? 32'(m_tag[addr]) : 32'd0);
        chk({req, " valid_out"}, 32'(valid_out), 32'(exp_rd() && m_v[addr]));
        chk({req, " dirty_out"}, 32'(dirty_out), 32'(exp_rd() && m_d[addr]));
    endtask

    task automatic enable_blk();
        sel_n = 1'b0; sel = 1'b1; sleep = 1'b0;
    endtask

    // Drive a write at the falling edge; the model follows at the rising edge
    task automatic do_write(logic [AW-1:0] a, logic [TW-1:0] t, logic v, logic d);
        @(negedge clk);
        addr = a; tag_in = t; valid_in = v; dirty_in = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        if (exp_active()) begin
            m_tag[a] = t;
            if (clear_n) begin m_v[a] = v; m_d[a] = d; end
        end
        #1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(logic [AW-1:0] a, logic [TW-1:0] t, logic q, string req);
        addr = a; tag_in = t; need_valid = q; rd_en = 1'b1; wr_en = 1'b0;
        #1;
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        process::self().srandom(32'd4711);
        for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_v[i] = 1'b0; m_d[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        enable_blk();
        rd_en = 1'b1; addr = 8'd5;
        #1;
        // reset state, R6: flags read as zero during clear
        chk("R6 reset valid", 32'(valid_out), 32'd0);
        chk("R6 reset dirty", 32'(dirty_out), 32'd0);
        chk("R8 reset rd_ok", 32'(rd_ok), 32'd1);
        @(negedge clk);
        clear_n = 1'b1;

        // fill every entry with a known tag (R1)
        for (int i = 0; i < DEPTH; i++)
            do_write(AW'(i), TW'($urandom), 1'($urandom), 1'($urandom));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            look(AW'(i * 7), m_tag[AW'(i * 7)], 1'b0, "R1 readback");
        end

        // R2/R3: valid flag off, tag equal
        do_write(8'd10, 14'h1abc, 1'b0, 1'b0);
        @(negedge clk);
        look(8'd10, 14'h1abc, 1'b0, "R2 hit without valid");
        chk("R2 hit", 32'(hit), 32'd1);
        look(8'd10, 14'h1abc, 1'b1, "R3 qualified no valid");
        chk("R3 no hit", 32'(hit), 32'd0);
        look(8'd10, 14'h1abd, 1'b0, "R2 tag differs");

        // R4: dirty toggled, hit unchanged
        do_write(8'd11, 14'h0f0f, 1'b1, 1'b0);
        @(negedge clk);
        look(8'd11, 14'h0f0f, 1'b1, "R4 dirty clear");
        chk("R4 hit clean", 32'(hit), 32'd1);
        do_write(8'd11, 14'h0f0f, 1'b1, 1'b1);
        @(negedge clk);
        look(8'd11, 14'h0f0f, 1'b1, "R4 dirty set");
        chk("R4 hit dirty", 32'(hit), 32'd1);

        // R5: outputs change without a clock edge
        @(negedge clk);
        look(8'd10, 14'h1abc, 1'b0, "R5 first addr");
        #0.5;
        look(8'd11, 14'h0f0f, 1'b0, "R5 second addr same cycle");
        chk("R5 tag follows", 32'(tag_out), 32'h0f0f);

        // R7: deselects and sleep block hit, read and write
        @(negedge clk);
        sel = 1'b0;
        look(8'd11, 14'h0f0f, 1'b0, "R7 sel low");
        sel = 1'b1; sel_n = 1'b1;
        look(8'd11, 14'h0f0f, 1'b0, "R7 sel_n high");
        sel_n = 1'b0; sleep = 1'b1;
        look(8'd11, 14'h0f0f, 1'b0, "R7 sleep");
        do_write(8'd11, 14'h2222, 1'b0, 1'b0);
        enable_blk();
        @(negedge clk);
        look(8'd11, 14'h0f0f, 1'b1, "R7 write blocked in sleep");
        chk("R7 tag kept", 32'(tag_out), 32'h0f0f);

        // R8: read gating by rd_en and wr_en
        @(negedge clk);
        look(8'd11, 14'h0f0f, 1'b0, "R8 base");
        rd_en = 1'b0; #1; check_all("R8 rd_en low");
        chk("R8 zero tag", 32'(tag_out), 32'd0);

        // R6 and R9: clear keeps tags, write during clear keeps only tag
        @(negedge clk);
        clear_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 1'b0; m_d[i] = 1'b0; end
        do_write(8'd12, 14'h3333, 1'b1, 1'b1);
        @(negedge clk);
        look(8'd12, 14'h3333, 1'b0, "R9 tag lands during clear");
        chk("R9 flags dropped", 32'(valid_out), 32'd0);
        look(8'd11, 14'h0f0f, 1'b0, "R6 tag kept after clear");
        chk("R6 hit unqualified", 32'(hit), 32'd1);
        look(8'd11, 14'h0f0f, 1'b1, "R6 qualified miss");
        chk("R6 dirty cleared", 32'(dirty_out), 32'd0);
        @(negedge clk);
        clear_n = 1'b1;

        // random mix
        for (int it = 0; it < 3000; it++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            sel_n = ($urandom % 8) == 0;
            sel = ($urandom % 8) != 0;
            sleep = ($urandom % 10) == 0;
            if ($urandom % 2) begin
                do_write(a, TW'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                @(negedge clk);
                rd_en = 1'($urandom);
                look(a, ($urandom % 2) ? m_tag[a] : TW'($urandom), 1'($urandom), "R1 R2 R3 R8 random");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule